// File: doc/BRIEF.md
# APB Serial Port Register Front-End

This block is the software-visible side of a serial port. An APB slave decodes a small register window and offers four views: a data register, a read-only status word, a fully writable control word, and a scaler that always reads zero. Bytes arriving from the line side come in on a byte-wide valid/ready stream and wait in a receive FIFO until software reads the data register. Each byte that software writes to the data register leaves on a byte-wide valid/ready output stream.

The bit-level serializer, baud generation, parity and flow control sit outside this block. Their control bits are only stored here and read back. A single interrupt line reports receive and transmit events as one-cycle pulses.

The window is decoded from the low 8 address bits only. Offsets are 0x00 (data, also reachable at 0x03 for byte accesses), 0x04 status, 0x08 control, 0x0C scaler and 0x10 FIFO debug, which reads zero. Every access completes in its access phase and never signals an error.

Top module: `apb_serial_regs`

## Requirements
- R1: After reset, control reads 0, status reads 0x0000_0006 (bits 1 and 2 set, meaning the transmit shift register and transmit FIFO are empty), the receive FIFO is empty, and rx_ready is low.
- R2: Only paddr[7:0] is decoded. Control at 0x08 stores all 32 bits and reads them back. Writes to status at 0x04 are ignored. The scaler at 0x0C reads 0 and ignores writes. Offset 0x10 and every other unlisted offset read 0.
- R3: An input byte is taken (rx_ready high) only while control bit 0 (receive enable) is set.
- R4: The receive FIFO holds DEPTH (16) bytes. rx_ready is low while it is full, so no byte is dropped. Status bit 10 is set when the FIFO is full, and status bit 8 when it holds DEPTH/2 or more bytes.
- R5: A read at offset 0x00 or 0x03 removes the oldest byte and returns it in prdata[7:0], with zeros above, in arrival order.
- R6: Status bit 0 (data ready) is 1 exactly when the FIFO holds a byte, so it clears once the last byte is read. A data read on an empty FIFO returns 0.
- R7: A write at offset 0x00 or 0x03 drives tx_valid high with tx_data = pwdata[7:0] during its access cycle, but only if control bit 1 (transmit enable) is set and tx_ready is high. Otherwise the byte is dropped.
- R8: irq is high for one cycle after a cycle in which a byte was taken while control bit 2 was set, or a byte was sent while control bit 3 was set. A receive and a transmit in the same cycle give a single one-cycle pulse. No other event raises irq.
- R9: pready is always 1 and pslverr is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Clock |
| presetn | input | 1 | Active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write strobe |
| paddr | input | AW | APB address; low 8 bits decoded |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | Always 1 |
| pslverr | output | 1 | Always 0 |
| rx_data | input | 8 | Incoming byte |
| rx_valid | input | 1 | Incoming byte valid |
| rx_ready | output | 1 | Block can take a byte |
| tx_data | output | 8 | Outgoing byte |
| tx_valid | output | 1 | Outgoing byte valid |
| tx_ready | input | 1 | Sink can take a byte |
| irq | output | 1 | Interrupt pulse |

## Verification
The hardest case to reach is a receive event and a transmit event in the same clock cycle, because one arrives on the stream side and the other on the bus side. The bench holds rx_valid high during the access phase of a data write with both interrupt enables set. It then checks that irq goes high for exactly one cycle and that both bytes were handled. The full-FIFO boundary is also directed: sixteen bytes are pushed and a seventeenth is offered. Random mixes of control values, pushes, byte-offset reads and writes, and tx_ready settings then cover the gating combinations.

// File: rtl/apb_serial_regs.sv
module apb_serial_regs #(
  parameter int DEPTH = 16,
  parameter int AW    = 12
) (
  input  logic          pclk,
  input  logic          presetn,
  input  logic          psel,
  input  logic          penable,
  input  logic          pwrite,
  input  logic [AW-1:0] paddr,
  input  logic [31:0]   pwdata,
  output logic [31:0]   prdata,
  output logic          pready,
  output logic          pslverr,
  input  logic [7:0]    rx_data,
  input  logic          rx_valid,
  output logic          rx_ready,
  output logic [7:0]    tx_data,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic          irq
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;
  localparam logic [CW-1:0] FULL = CW'(DEPTH);
  localparam logic [CW-1:0] HALF = CW'(DEPTH / 2);

  logic [7:0]    mem [DEPTH];
  logic [PW-1:0] rp, wp;
  logic [CW-1:0] cnt;
  logic [31:0]   ctrl, status;

  wire [7:0] off      = 8'(paddr);
  wire       acc      = psel & penable;
  wire       data_hit = (off == 8'h00) || (off == 8'h03);
  wire       wr       = acc & pwrite;
  wire       rd       = acc & ~pwrite;
  wire       nonempty = (cnt != '0);
  wire       pop      = rd & data_hit & nonempty;
  wire       push     = rx_valid & rx_ready;
  wire       sent     = wr & data_hit & ctrl[1] & tx_ready;

  assign rx_ready = ctrl[0] & (cnt != FULL);
  assign tx_valid = sent;
  assign tx_data  = pwdata[7:0];
  assign pready   = 1'b1;
  assign pslverr  = 1'b0;

  assign status = {21'b0, cnt == FULL, 1'b0, cnt >= HALF, 1'b0, 4'b0, 2'b11, nonempty};

  always_comb begin
    prdata = '0;
    if (rd) begin
      case (off)
        8'h00, 8'h03: prdata = nonempty ? {24'b0, mem[rp]} : 32'b0;
        8'h04:        prdata = status;
        8'h08:        prdata = ctrl;
        default:      prdata = '0;
      endcase
    end
  end

  always_ff @(posedge pclk) begin
    if (push) mem[wp] <= rx_data;
  end

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      ctrl <= '0;
      rp   <= '0;
      wp   <= '0;
      cnt  <= '0;
      irq  <= 1'b0;
    end else begin
      if (wr && off == 8'h08) ctrl <= pwdata;
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
      cnt <= cnt + CW'(push) - CW'(pop);
      irq <= (push & ctrl[2]) | (sent & ctrl[3]);
    end
  end

  assert_no_overflow_R4: assert property (@(posedge pclk) disable iff (!presetn)
    (cnt == FULL) |-> !rx_ready);

  assert_rx_gate_R3: assert property (@(posedge pclk) disable iff (!presetn)
    !ctrl[0] |-> !rx_ready);

  assert_tx_gate_R7: assert property (@(posedge pclk) disable iff (!presetn)
    tx_valid |-> (tx_ready && pwrite && psel && penable));

  assert_irq_cause_R8: assert property (@(posedge pclk) disable iff (!presetn)
    $rose(irq) |-> $past((rx_valid && rx_ready) || tx_valid));

  assert_empty_read_R6: assert property (@(posedge pclk) disable iff (!presetn)
    (rd && data_hit && status[0] == 1'b0) |-> (prdata == 32'b0));

  assert_count_step_R5: assert property (@(posedge pclk) disable iff (!presetn)
    (!rx_valid && !(psel && penable)) |=> $stable(cnt));
endmodule

// File: tb/sim_apb_serial_regs.sv
module sim_apb_serial_regs;
  logic        pclk = 0, presetn = 0;
  logic        psel = 0, penable = 0, pwrite = 0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0, prdata;
  logic        pready, pslverr;
  logic [7:0]  rx_data = '0, tx_data;
  logic        rx_valid = 0, rx_ready, tx_valid, tx_ready = 1, irq;

  int checks = 0, fails = 0;
  byte unsigned q[$];
  logic [31:0] mctrl = '0;

  always #2 pclk = ~pclk;

  apb_serial_regs u0 (.pclk, .presetn, .psel, .penable, .pwrite, .paddr, .pwdata,
    .prdata, .pready, .pslverr, .rx_data, .rx_valid, .rx_ready, .tx_data,
    .tx_valid, .tx_ready, .irq);

  function automatic logic [31:0] exp_status(int n);
    return 32'h6 | 32'(n != 0) | (32'(n >= 8) << 8) | (32'(n == 16) << 10);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic apb(input bit wr, input logic [11:0] a, input logic [31:0] d, input bit rxv,
                     input logic [7:0] rxd, output logic [31:0] rdat, output bit txv,
                     output logic [7:0] txd, output bit irq_after, output bit rx_took);
    @(negedge pclk);
    psel = 1; penable = 0; pwrite = wr; paddr = a; pwdata = d;
    @(negedge pclk);
    penable = 1; rx_valid = rxv; rx_data = rxd;
    #1;
    rdat = prdata; txv = tx_valid; txd = tx_data; rx_took = rxv && rx_ready;
    chk(pready === 1'b1 && pslverr === 1'b0, "R9", {pready, pslverr}, 2'b10);
    @(negedge pclk);
    irq_after = irq;
    psel = 0; penable = 0; pwrite = 0; rx_valid = 0;
  endtask

  task automatic rd_reg(input logic [11:0] a, output logic [31:0] v);
    bit t, i, r; logic [7:0] x;
    apb(0, a, 0, 0, 0, v, t, x, i, r);
  endtask

  task automatic wr_reg(input logic [11:0] a, input logic [31:0] v);
    bit t, i, r; logic [7:0] x; logic [31:0] rd;
    apb(1, a, v, 0, 0, rd, t, x, i, r);
    if (a[7:0] == 8'h08) mctrl = v;
  endtask

  task automatic do_push(input logic [7:0] b);
    bit acc, ir;
    @(negedge pclk);
    rx_valid = 1; rx_data = b;
    #1 acc = rx_ready;
    @(negedge pclk);
    rx_valid = 0; ir = irq;
    chk(acc == (mctrl[0] && q.size() < 16), "R3/R4 accept", acc, mctrl[0] && q.size() < 16);
    chk(ir == (acc && mctrl[2]), "R8 rx irq", ir, acc && mctrl[2]);
    if (acc) q.push_back(b);
  endtask

  task automatic do_read(input logic [11:0] a);
    logic [31:0] v, e;
    rd_reg(a, v);
    e = (q.size() != 0) ? 32'(q.pop_front()) : 32'h0;
    chk(v === e, "R5/R6 data read", v, e);
  endtask

  task automatic do_tx(input logic [11:0] a, input logic [31:0] d);
    bit txv, ir, r; logic [7:0] txd; logic [31:0] rd; bit e;
    apb(1, a, d, 0, 0, rd, txv, txd, ir, r);
    e = mctrl[1] && tx_ready;
    chk(txv == e, "R7 tx_valid", txv, e);
    if (e) chk(txd === d[7:0], "R7 tx_data", txd, d[7:0]);
    chk(ir == (e && mctrl[3]), "R8 tx irq", ir, e && mctrl[3]);
  endtask

  task automatic chk_status(input string req);
    logic [31:0] v;
    rd_reg(12'h004, v);
    chk(v === exp_status(q.size()), req, v, exp_status(q.size()));
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge pclk);
    presetn = 1;
    @(negedge pclk);
    // R1 reset state
    chk(rx_ready === 1'b0, "R1 rx_ready", rx_ready, 0);
    chk(irq === 1'b0, "R1 irq", irq, 0);
    rd_reg(12'h004, v); chk(v === 32'h6, "R1 status", v, 32'h6);
    rd_reg(12'h008, v); chk(v === 32'h0, "R1 control", v, 0);
    do_read(12'h000);
    // R2 decoding
    wr_reg(12'h008, 32'h8000_1FF0); rd_reg(12'h008, v);
    chk(v === 32'h8000_1FF0, "R2 control readback", v, 32'h8000_1FF0);
    rd_reg(12'h308, v); chk(v === 32'h8000_1FF0, "R2 low-8 masking", v, 32'h8000_1FF0);
    wr_reg(12'h004, 32'hFFFF_FFFF); chk_status("R2 status write ignored");
    wr_reg(12'h00C, 32'h1234); rd_reg(12'h00C, v); chk(v === 0, "R2 scaler", v, 0);
    rd_reg(12'h010, v); chk(v === 0, "R2 debug offset", v, 0);
    rd_reg(12'h014, v); chk(v === 0, "R2 unknown offset", v, 0);
    rd_reg(12'h0FC, v); chk(v === 0, "R2 unknown offset", v, 0);
    // R3 disabled receive
    do_push(8'hAA); chk_status("R3 nothing taken");
    // R4 fill to full
    wr_reg(12'h008, 32'h5);
    for (int i = 0; i < 16; i++) begin
      do_push(8'(8'h10 + i));
      if (i == 6 || i == 7 || i == 15) chk_status("R4 half/full flags");
    end
    do_push(8'hEE);
    chk(q.size() == 16, "R4 no drop", q.size(), 16);
    // R5/R6 drain through both offsets
    for (int i = 0; i < 16; i++) do_read(i % 2 ? 12'h003 : 12'h000);
    chk_status("R6 data ready cleared");
    do_read(12'h003);
    // R7 transmit gating
    tx_ready = 1; do_tx(12'h000, 32'h55);
    wr_reg(12'h008, 32'hA); tx_ready = 0; do_tx(12'h000, 32'h66);
    tx_ready = 1; do_tx(12'h003, 32'hABCD_EF77);
    // R8 simultaneous events yield one pulse
    wr_reg(12'h008, 32'hF);
    begin
      bit txv, ir, r; logic [7:0] txd; logic [31:0] rd;
      apb(1, 12'h000, 32'h3C, 1, 8'hC3, rd, txv, txd, ir, r);
      chk(txv && r, "R8 both events", {txv, r}, 2'b11);
      if (r) q.push_back(8'hC3);
      chk(ir === 1'b1, "R8 pulse high", ir, 1);
      @(negedge pclk);
      chk(irq === 1'b0, "R8 single cycle", irq, 0);
    end
    do_read(12'h000);
    // random mix
    for (int n = 0; n < 600; n++) begin
      int op = $urandom_range(0, 9);
      case (op)
        0, 1, 2: do_push(8'($urandom));
        3, 4:    do_read($urandom_range(0, 1) ? 12'h003 : 12'h000);
        5, 6:    begin tx_ready = 1'($urandom); do_tx($urandom_range(0, 1) ? 12'h003 : 12'h000, $urandom); end
        7:       wr_reg(12'h008, $urandom);
        8:       chk_status("R4/R6 random status");
        default: begin rd_reg(12'h008, v); chk(v === mctrl, "R2 random control", v, mctrl); end
      endcase
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule